// File: doc/BRIEF.md
# Bus Trigger and Capture Unit

This block sits beside a CPU and watches every bus access it makes: the address, the data byte, the read/write direction and a strobe that marks opcode fetches. Two comparators, A and B, are loaded through a small write-only configuration port. A 4-bit mode field then combines their results into a trigger condition. The conditions available are a single match, an OR, a sequence, two data-qualified forms, two event-capture forms and two address-range forms.

While armed, the unit fills an eight-entry, 16-bit capture FIFO. In the capture-on-event modes, each qualifying B access pushes its data byte. In every other mode, the unit pushes the destination address of each change of flow. The condition completing ends the run: the unit disarms itself, sets a sticky triggered flag and pulses a force breakpoint toward the CPU. It also raises a tag breakpoint when the matching access was an opcode fetch. A debugger drains the FIFO afterwards through a pop strobe.

Top module: `busTrigUnit`

## Requirements
- R1: Configuration writes select a register by `cfgAddr`: 0 sets comparator A address, 1 sets comparator B address, 2 sets the B data byte (bits 7:0), 3 sets control. The control fields are mode in bits 3:0, A direction-check enable in bit 4, A direction value in bit 5, B direction-check enable in bit 6, B direction value in bit 7 and arm in bit 8. A control write always loads `armed` from bit 8. When bit 8 is 1, the same write also empties the FIFO, clears the sequence memory and clears `trigd`. No bus evaluation happens in a cycle with `cfgWe` high.
- R2: Comparator A matches when `busValid` is high and `busAddr` equals the A address, and also either its direction check is disabled or `busRw` (1 = read) equals its direction value. Comparator B matches the same way using its own settings.
- R3: Mode 0 triggers on an A match. Mode 1 triggers on an A match or a B match.
- R4: Mode 2 triggers on a B match only when an A match occurred in an earlier cycle of the same armed run. An access that matches A and B together in one cycle does not trigger by itself.
- R5: Mode 3 triggers on an A match whose `busData` equals the B data byte. Mode 4 triggers on an A match whose `busData` differs from that byte.
- R6: Mode 7 triggers when A ≤ `busAddr` ≤ B. Mode 8 triggers when `busAddr` < A or `busAddr` > B. Both modes apply only to a valid access, and both apply comparator A's direction check.
- R7: Mode values 9 to 15 never trigger.
- R8: In mode 5, every B match pushes `{8'h00, busData}`. Mode 6 does the same, but only after an earlier A match. The push that brings the count to 8 is the trigger. B matches seen before the qualifying A match push nothing.
- R9: In all modes other than 5 and 6, each cycle with `cofValid` high while armed pushes `cofAddr`. When the FIFO already holds 8 entries, the push drops the oldest entry and the count stays at 8.
- R10: `fifoRdata` shows the oldest entry and `fifoCount` gives the number held (0 to 8). A `fifoRd` pulse removes one entry. With an empty FIFO, `fifoRdata` is 0 and a read leaves the count at 0.
- R11: When the condition completes, `armed` falls and `trigd` rises on the next edge, and `forceBrk` is high for exactly that one cycle. `trigd` stays set until the next arming write.
- R12: `tagBrk` pulses together with `forceBrk` only when `busFetch` was high in the cycle that completed the condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgWdata | input | 16 | Configuration write data |
| busValid | input | 1 | A bus access happens this cycle |
| busAddr | input | 16 | Access address |
| busData | input | 8 | Access data byte |
| busRw | input | 1 | 1 = read, 0 = write |
| busFetch | input | 1 | Access is an opcode fetch |
| cofValid | input | 1 | Change of flow this cycle |
| cofAddr | input | 16 | Change-of-flow destination address |
| fifoRd | input | 1 | Pop the oldest FIFO entry |
| fifoRdata | output | 16 | Oldest FIFO entry, 0 when empty |
| fifoCount | output | 4 | Entries held |
| armed | output | 1 | Unit is armed |
| trigd | output | 1 | Trigger has completed since the last arming |
| forceBrk | output | 1 | One-cycle force breakpoint |
| tagBrk | output | 1 | Tag breakpoint for a fetched opcode |

## Verification
The assertions assume that `fifoRd` and the bus inputs are meaningful only after reset is released, and that nothing besides the arming write clears the triggered flag. Two of them assume no change-of-flow pushes happen while the unit is disarmed, which holds because capture is gated by `armed`. The stimulus changes inputs only on falling edges, holds every strobe for exactly one cycle, and never mixes a configuration write with a bus access. This keeps the rule that configuration takes priority out of the way of the trigger checks, while the reference model still follows that rule.

// File: rtl/busTrigPkg.sv
package busTrigPkg;
  // Configuration register select
  localparam logic [1:0] REG_CMP_A  = 2'd0;
  localparam logic [1:0] REG_CMP_B  = 2'd1;
  localparam logic [1:0] REG_BDATA  = 2'd2;
  localparam logic [1:0] REG_CTRL   = 2'd3;

  // Control word bit positions
  localparam int CTL_A_RWEN  = 4;
  localparam int CTL_A_RWVAL = 5;
  localparam int CTL_B_RWEN  = 6;
  localparam int CTL_B_RWVAL = 7;
  localparam int CTL_ARM     = 8;

  // Trigger mode codes
  localparam logic [3:0] MD_A_ONLY     = 4'd0;
  localparam logic [3:0] MD_A_OR_B     = 4'd1;
  localparam logic [3:0] MD_A_THEN_B   = 4'd2;
  localparam logic [3:0] MD_A_DATA_EQ  = 4'd3;
  localparam logic [3:0] MD_A_DATA_NE  = 4'd4;
  localparam logic [3:0] MD_EVT_B      = 4'd5;
  localparam logic [3:0] MD_A_THEN_EVT = 4'd6;
  localparam logic [3:0] MD_IN_RANGE   = 4'd7;
  localparam logic [3:0] MD_OUT_RANGE  = 4'd8;

  // Datapath -> control: comparator results
  typedef struct packed {
    logic aHit;
    logic bHit;
    logic dataEq;
    logic inRange;
    logic outRange;
  } cmpHits_t;

  // Control -> datapath: FIFO strobes
  typedef struct packed {
    logic clear;
    logic pushCof;
    logic pushEvt;
    logic pop;
  } fifoStb_t;
endpackage

// File: rtl/busTrigData.sv
module busTrigData
  import busTrigPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busRw,
  input  logic [ADDR_W-1:0] cofAddr,
  input  fifoStb_t          stb,
  output cmpHits_t          hits,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] rdata
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] cmpA, cmpB;
  logic [DATA_W-1:0] cmpData;
  logic aRwEn, aRwVal, bRwEn, bRwVal;

  // Comparator configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpA <= '0; cmpB <= '0; cmpData <= '0;
      aRwEn <= 1'b0; aRwVal <= 1'b0; bRwEn <= 1'b0; bRwVal <= 1'b0;
    end else if (cfgWe) begin
      case (cfgAddr)
        REG_CMP_A: cmpA    <= cfgWdata;
        REG_CMP_B: cmpB    <= cfgWdata;
        REG_BDATA: cmpData <= cfgWdata[DATA_W-1:0];
        default: begin
          aRwEn  <= cfgWdata[CTL_A_RWEN];
          aRwVal <= cfgWdata[CTL_A_RWVAL];
          bRwEn  <= cfgWdata[CTL_B_RWEN];
          bRwVal <= cfgWdata[CTL_B_RWVAL];
        end
      endcase
    end
  end

  logic dirOkA, dirOkB;
  always_comb begin
    dirOkA        = !aRwEn || (busRw == aRwVal);
    dirOkB        = !bRwEn || (busRw == bRwVal);
    hits.aHit     = busValid && dirOkA && (busAddr == cmpA);
    hits.bHit     = busValid && dirOkB && (busAddr == cmpB);
    hits.dataEq   = (busData == cmpData);
    hits.inRange  = busValid && dirOkA && (busAddr >= cmpA) && (busAddr <= cmpB);
    hits.outRange = busValid && dirOkA && ((busAddr < cmpA) || (busAddr > cmpB));
  end

  // Capture FIFO
  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic              push, full, doPop;
  logic [ADDR_W-1:0] entry;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  generate
    if (ADDR_W > DATA_W) begin : g_zext
      assign entry = stb.pushEvt ? {{(ADDR_W-DATA_W){1'b0}}, busData} : cofAddr;
    end else begin : g_trunc
      assign entry = stb.pushEvt ? busData[ADDR_W-1:0] : cofAddr;
    end
  endgenerate

  assign push  = stb.pushCof || stb.pushEvt;
  assign full  = (count == CNT_FULL);
  assign doPop = stb.pop && (count != '0);

  always_ff @(posedge clk) begin
    if (push) mem[tail] <= entry;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      head <= '0; tail <= '0; count <= '0;
    end else begin
      if (push) tail <= nextPtr(tail);
      if ((push && full) || doPop) head <= nextPtr(head);
      if (push && !full && !doPop)      count <= count + 1'b1;
      else if (doPop && !push)          count <= count - 1'b1;
    end
  end

  assign rdata = (count == '0) ? '0 : mem[head];
endmodule

// File: rtl/busTrigCtrl.sv
module busTrigCtrl
  import busTrigPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [8:0]       cfgCtl,
  input  logic             busFetch,
  input  logic             cofValid,
  input  logic             fifoRd,
  input  cmpHits_t         hits,
  input  logic [CNT_W-1:0] count,
  output fifoStb_t         stb,
  output logic             armed,
  output logic             trigd,
  output logic             forceBrk,
  output logic             tagBrk
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

  logic [3:0] mode;
  logic       seenA;
  logic       ctlWr, armWr, busOk, evtMode, evtQual, cond, fire;

  assign ctlWr   = cfgWe && (cfgAddr == REG_CTRL);
  assign armWr   = ctlWr && cfgCtl[CTL_ARM];
  assign busOk   = armed && !cfgWe;
  assign evtMode = (mode == MD_EVT_B) || (mode == MD_A_THEN_EVT);
  assign evtQual = hits.bHit && ((mode == MD_EVT_B) || seenA);

  always_comb begin
    case (mode)
      MD_A_ONLY:    cond = hits.aHit;
      MD_A_OR_B:    cond = hits.aHit || hits.bHit;
      MD_A_THEN_B:  cond = hits.bHit && seenA;
      MD_A_DATA_EQ: cond = hits.aHit && hits.dataEq;
      MD_A_DATA_NE: cond = hits.aHit && !hits.dataEq;
      MD_IN_RANGE:  cond = hits.inRange;
      MD_OUT_RANGE: cond = hits.outRange;
      default:      cond = 1'b0;
    endcase
  end

  always_comb begin
    stb.clear   = armWr;
    stb.pop     = fifoRd && !armWr;
    stb.pushEvt = busOk && evtMode && evtQual;
    stb.pushCof = busOk && !evtMode && cofValid;
  end

  assign fire = busOk && (evtMode ? (stb.pushEvt && (count == CNT_LAST) && !fifoRd)
                                  : cond);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= MD_A_ONLY; armed <= 1'b0; trigd <= 1'b0; seenA <= 1'b0;
      forceBrk <= 1'b0; tagBrk <= 1'b0;
    end else begin
      forceBrk <= fire;
      tagBrk   <= fire && busFetch;
      if (ctlWr) begin
        mode  <= cfgCtl[3:0];
        armed <= cfgCtl[CTL_ARM];
        if (armWr) begin
          trigd <= 1'b0;
          seenA <= 1'b0;
        end
      end else begin
        if (fire) begin
          armed <= 1'b0;
          trigd <= 1'b1;
        end
        if (busOk && hits.aHit) seenA <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/busTrigUnit.sv
module busTrigUnit
  import busTrigPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busRw,
  input  logic              busFetch,
  input  logic              cofValid,
  input  logic [ADDR_W-1:0] cofAddr,
  input  logic              fifoRd,
  output logic [ADDR_W-1:0] fifoRdata,
  output logic [$clog2(DEPTH+1)-1:0] fifoCount,
  output logic              armed,
  output logic              trigd,
  output logic              forceBrk,
  output logic              tagBrk
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  cmpHits_t hits;
  fifoStb_t stb;

  busTrigData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .busValid(busValid), .busAddr(busAddr), .busData(busData), .busRw(busRw),
    .cofAddr(cofAddr), .stb(stb), .hits(hits), .count(fifoCount), .rdata(fifoRdata)
  );

  busTrigCtrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgCtl(cfgWdata[8:0]),
    .busFetch(busFetch), .cofValid(cofValid), .fifoRd(fifoRd), .hits(hits),
    .count(fifoCount), .stb(stb), .armed(armed), .trigd(trigd),
    .forceBrk(forceBrk), .tagBrk(tagBrk)
  );
endmodule

// File: rtl/busTrigChk.sv
module busTrigChk #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [1:0]        cfgAddr,
  input logic [ADDR_W-1:0] cfgWdata,
  input logic              fifoRd,
  input logic [ADDR_W-1:0] fifoRdata,
  input logic [CNT_W-1:0]  fifoCount,
  input logic              armed,
  input logic              trigd,
  input logic              forceBrk,
  input logic              tagBrk
);
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgAddr == 2'd3 && cfgWdata[8]) |=> (fifoCount == '0 && armed && !trigd)); // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH)); // R9
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0) |-> (fifoRdata == '0)); // R10
  AST_IDLE_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !cfgWe && fifoRd && fifoCount == '0) |=> (fifoCount == '0)); // R10
  AST_IDLE_POP: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !cfgWe && fifoRd && fifoCount != '0) |=> (fifoCount == $past(fifoCount) - 1'b1)); // R10
  AST_FORCE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    forceBrk |=> !forceBrk); // R11
  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    forceBrk |-> (!armed && trigd)); // R11
  AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (trigd && !cfgWe) |=> trigd); // R11
  AST_TAG_WITH_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    tagBrk |-> forceBrk); // R12
endmodule

bind busTrigUnit busTrigChk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
  .fifoRd(fifoRd), .fifoRdata(fifoRdata), .fifoCount(fifoCount), .armed(armed),
  .trigd(trigd), .forceBrk(forceBrk), .tagBrk(tagBrk)
);

// File: tb/tb_busTrigUnit.sv
module tb_busTrigUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgAddr = 2'd0;
  logic [15:0] cfgWdata = 16'd0;
  logic busValid = 1'b0;
  logic [15:0] busAddr = 16'd0;
  logic [7:0] busData = 8'd0;
  logic busRw = 1'b0;
  logic busFetch = 1'b0;
  logic cofValid = 1'b0;
  logic [15:0] cofAddr = 16'd0;
  logic fifoRd = 1'b0;
  logic [15:0] fifoRdata;
  logic [3:0] fifoCount;
  logic armed, trigd, forceBrk, tagBrk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  busTrigUnit dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .busValid(busValid), .busAddr(busAddr), .busData(busData), .busRw(busRw),
    .busFetch(busFetch), .cofValid(cofValid), .cofAddr(cofAddr), .fifoRd(fifoRd),
    .fifoRdata(fifoRdata), .fifoCount(fifoCount), .armed(armed), .trigd(trigd),
    .forceBrk(forceBrk), .tagBrk(tagBrk)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int mA, mB, mBd, mMode;
  bit aEn, aVal, bEn, bVal, mArmed, mTrig, mSeen, mForce, mTag;
  int q[$];

  always @(posedge clk) begin
    bit armWr, qa, qb, ahit, bhit, ev, cond, f;
    if (!rstN) begin
      mA = 0; mB = 0; mBd = 0; mMode = 0;
      aEn = 0; aVal = 0; bEn = 0; bVal = 0;
      mArmed = 0; mTrig = 0; mSeen = 0; mForce = 0; mTag = 0;
      q.delete();
    end else begin
      armWr = cfgWe && cfgAddr == 2'd3 && cfgWdata[8];
      f = 0; mForce = 0; mTag = 0;
      if (!armWr && fifoRd && q.size() > 0) void'(q.pop_front());
      if (cfgWe) begin
        case (cfgAddr)
          2'd0: mA = cfgWdata;
          2'd1: mB = cfgWdata;
          2'd2: mBd = cfgWdata[7:0];
          default: begin
            mMode = cfgWdata[3:0];
            aEn = cfgWdata[4]; aVal = cfgWdata[5];
            bEn = cfgWdata[6]; bVal = cfgWdata[7];
            mArmed = cfgWdata[8];
            if (armWr) begin q.delete(); mSeen = 0; mTrig = 0; end
          end
        endcase
      end else if (mArmed) begin
        qa = !aEn || (busRw == aVal);
        qb = !bEn || (busRw == bVal);
        ahit = busValid && qa && (busAddr == mA);
        bhit = busValid && qb && (busAddr == mB);
        ev = (mMode == 5) || (mMode == 6);
        case (mMode)
          0: cond = ahit;
          1: cond = ahit || bhit;
          2: cond = bhit && mSeen;
          3: cond = ahit && (busData == mBd);
          4: cond = ahit && (busData != mBd);
          7: cond = busValid && qa && busAddr >= mA && busAddr <= mB;
          8: cond = busValid && qa && (busAddr < mA || busAddr > mB);
          default: cond = 0;
        endcase
        if (ev) begin
          if (bhit && (mMode == 5 || mSeen)) begin
            q.push_back(busData);
            if (q.size() == 8) f = 1;
          end
        end else begin
          if (cofValid) begin
            if (q.size() == 8) void'(q.pop_front());
            q.push_back(cofAddr);
          end
          f = cond;
        end
        if (ahit) mSeen = 1;
        if (f) begin mArmed = 0; mTrig = 1; mForce = 1; mTag = busFetch; end
      end
    end
  end

  // Compare against the model on every cycle
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(armed === mArmed, "R11 armed", armed, mArmed);
      chk(trigd === mTrig, "R11 trigd", trigd, mTrig);
      chk(forceBrk === mForce, "R11 forceBrk", forceBrk, mForce);
      chk(tagBrk === mTag, "R12 tagBrk", tagBrk, mTag);
      chk(fifoCount === 4'(q.size()), "R9 fifoCount", fifoCount, q.size());
      chk(fifoRdata === ((q.size() > 0) ? 16'(q[0]) : 16'd0), "R10 fifoRdata",
          fifoRdata, (q.size() > 0) ? q[0] : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wrCfg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfgWe = 1; cfgAddr = a; cfgWdata = d;
    @(negedge clk); cfgWe = 0;
  endtask

  function automatic logic [15:0] ctl(input int md, input bit arm,
      input bit ae = 0, input bit av = 0, input bit be = 0, input bit bv = 0);
    return 16'((arm << 8) | (bv << 7) | (be << 6) | (av << 5) | (ae << 4) | (md & 15));
  endfunction

  task automatic acc(input logic [15:0] a, input logic [7:0] d, input bit rw, input bit fetch);
    @(negedge clk); busValid = 1; busAddr = a; busData = d; busRw = rw; busFetch = fetch;
    @(negedge clk); busValid = 0; busFetch = 0;
  endtask

  task automatic cof(input logic [15:0] a);
    @(negedge clk); cofValid = 1; cofAddr = a;
    @(negedge clk); cofValid = 0;
  endtask

  task automatic popChk(input logic [15:0] exp, input string tag);
    @(negedge clk);
    chk(fifoRdata === exp, tag, fifoRdata, exp);
    fifoRd = 1;
    @(negedge clk); fifoRd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(armed === 0 && trigd === 0 && fifoCount === 0 && forceBrk === 0, "R1 reset state",
        {armed, trigd, fifoCount}, 0);

    // R2/R3: mode 0 with A restricted to reads
    wrCfg(2'd0, 16'h1000);
    wrCfg(2'd3, ctl(0, 1, 1, 1));
    acc(16'h1000, 8'h00, 0, 0);
    chk(trigd === 0, "R2 write filtered by direction", trigd, 0);
    acc(16'h1000, 8'h00, 1, 0);
    chk(forceBrk === 1 && trigd === 1 && armed === 0, "R3 mode0 fire", {forceBrk, trigd, armed}, 3'b110);
    chk(tagBrk === 0, "R12 no tag without fetch", tagBrk, 0);
    @(negedge clk);
    chk(forceBrk === 0, "R11 force is one cycle", forceBrk, 0);

    // R3/R12: mode 1 fires on B, fetch gives a tag
    wrCfg(2'd1, 16'h1100);
    wrCfg(2'd3, ctl(1, 1));
    acc(16'h0FFF, 8'h00, 1, 1);
    chk(trigd === 0, "R3 mode1 miss", trigd, 0);
    acc(16'h1100, 8'h00, 1, 1);
    chk(forceBrk === 1 && tagBrk === 1, "R12 tag on fetched match", {forceBrk, tagBrk}, 2'b11);

    // R4: sequence; A and B on the same address
    wrCfg(2'd0, 16'h3000);
    wrCfg(2'd1, 16'h3000);
    wrCfg(2'd3, ctl(2, 1));
    acc(16'h3000, 8'h00, 1, 0);
    chk(trigd === 0, "R4 simultaneous A and B", trigd, 0);
    acc(16'h3000, 8'h00, 1, 0);
    chk(trigd === 1, "R4 B after A", trigd, 1);
    wrCfg(2'd1, 16'h3001);
    wrCfg(2'd3, ctl(2, 1));
    acc(16'h3001, 8'h00, 0, 0);
    chk(trigd === 0, "R4 B before A", trigd, 0);

    // R5: data-qualified modes
    wrCfg(2'd2, 16'h005A);
    wrCfg(2'd3, ctl(3, 1));
    acc(16'h3000, 8'h5B, 1, 0);
    chk(trigd === 0, "R5 data mismatch mode3", trigd, 0);
    acc(16'h3000, 8'h5A, 1, 0);
    chk(trigd === 1, "R5 data match mode3", trigd, 1);
    wrCfg(2'd3, ctl(4, 1));
    acc(16'h3000, 8'h5A, 1, 0);
    chk(trigd === 0, "R5 equal data mode4", trigd, 0);
    acc(16'h3000, 8'h11, 1, 0);
    chk(trigd === 1, "R5 unequal data mode4", trigd, 1);

    // R6: range modes
    wrCfg(2'd0, 16'h2000);
    wrCfg(2'd1, 16'h20FF);
    wrCfg(2'd3, ctl(7, 1));
    acc(16'h1FFF, 8'h00, 1, 0);
    chk(trigd === 0, "R6 below range", trigd, 0);
    acc(16'h2000, 8'h00, 1, 0);
    chk(trigd === 1, "R6 lower bound inside", trigd, 1);
    wrCfg(2'd3, ctl(8, 1));
    acc(16'h20FF, 8'h00, 1, 0);
    chk(trigd === 0, "R6 upper bound not outside", trigd, 0);
    acc(16'h2100, 8'h00, 1, 0);
    chk(trigd === 1, "R6 above range", trigd, 1);

    // R7: reserved mode
    wrCfg(2'd0, 16'h6000);
    wrCfg(2'd1, 16'h6000);
    wrCfg(2'd3, ctl(12, 1));
    acc(16'h6000, 8'h00, 1, 1);
    acc(16'h0000, 8'h00, 0, 0);
    chk(trigd === 0 && armed === 1, "R7 reserved never fires", {trigd, armed}, 2'b01);

    // R8: event store on B
    wrCfg(2'd1, 16'h4000);
    wrCfg(2'd3, ctl(5, 1));
    for (int i = 0; i < 7; i++) acc(16'h4000, 8'(8'hA0 + i), i[0], 0);
    chk(trigd === 0 && fifoCount === 7, "R8 seven events", {trigd, fifoCount}, 7);
    acc(16'h4000, 8'hA7, 1, 0);
    chk(trigd === 1 && fifoCount === 8, "R8 eighth event fires", {trigd, fifoCount}, 5'h18);
    for (int i = 0; i < 8; i++) popChk(16'(16'h00A0 + i), "R8 zero-extended event data");

    // R8: A then event-only B
    wrCfg(2'd0, 16'h5000);
    wrCfg(2'd1, 16'h5001);
    wrCfg(2'd3, ctl(6, 1));
    acc(16'h5001, 8'h33, 1, 0);
    chk(fifoCount === 0, "R8 B before A not stored", fifoCount, 0);
    acc(16'h5000, 8'h00, 1, 0);
    for (int i = 0; i < 8; i++) acc(16'h5001, 8'(i), 1, 0);
    chk(trigd === 1 && fifoCount === 8, "R8 sequenced events fill", {trigd, fifoCount}, 5'h18);

    // R1/R9/R10: change-of-flow capture with overwrite
    wrCfg(2'd0, 16'hFFFF);
    wrCfg(2'd3, ctl(0, 1));
    chk(fifoCount === 0 && trigd === 0, "R1 arm clears", {fifoCount, trigd}, 0);
    for (int i = 0; i < 10; i++) cof(16'(16'h0100 + i));
    chk(fifoCount === 8 && fifoRdata === 16'h0102, "R9 oldest dropped", fifoRdata, 16'h0102);
    for (int i = 2; i < 10; i++) popChk(16'(16'h0100 + i), "R10 pop order");
    @(negedge clk);
    fifoRd = 1;
    @(negedge clk); fifoRd = 0;
    chk(fifoCount === 0 && fifoRdata === 0, "R10 empty read", {fifoCount, fifoRdata}, 0);
    for (int i = 0; i < 3; i++) cof(16'(16'h0200 + i));
    wrCfg(2'd3, ctl(0, 1));
    chk(fifoCount === 0 && armed === 1, "R1 rearm empties FIFO", {fifoCount, armed}, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule